// File: doc/BRIEF.md
# Serial Display Link Pixel Unpacker

This block sits behind the receivers of a four-pair serial display link whose bits have already been sampled at seven times the pixel rate. It takes one bit per cycle from the clock pair and one from each data pair. It finds where each seven-bit pixel word starts by matching the clock pair's bit history against its fixed high/low shape. It then gathers the seven bits of every data pair and rearranges them into 8-bit red, green and blue values plus horizontal sync, vertical sync and data enable.

Three slot layouts are supported: a three-pair 18-bit layout and two four-pair 24-bit layouts. The two 24-bit layouts differ in whether the fourth pair carries the two least significant or the two most significant bits of each colour. The layout is chosen by a mode input that may change between words. While the block is aligned it gives a one-cycle strobe for each recovered pixel. A lock output shows whether it is aligned, and a sticky flag records a reserved control bit that arrived set.

Top module: `lvds_pixel_deser`

## Requirements
- R1: A word boundary is found at any bit offset where the last seven clock-pair bits, oldest first, read 1100011. `lock_o` rises at the edge that samples the last bit of the fourth consecutive matching word at that offset, and it stays low before that edge.
- R2: Before lock, a word whose clock pattern does not match clears the match count. Four further consecutive matching words are then needed to lock.
- R3: While locked, one mismatching word leaves `lock_o` high. Two consecutive mismatching words drop `lock_o` at the edge of the second one, and the search restarts.
- R4: `pix_valid_o` is a single-cycle pulse. It is given only for words that complete while `lock_o` was already high, and it appears in the cycle after the edge that samples slot 6.
- R5: Modes 0 and 3 select the 18-bit layout. Lane 0 carries G0 in slot 0 and R5..R0 in slots 1..6. Lane 1 carries B1, B0 in slots 0, 1 and G5..G1 in slots 2..6. Lane 2 carries B5..B2 in slots 3..6. Output colour bits 7:6 are 0, and lane 3 has no effect on any output.
- R6: Mode 1 uses the lanes 0-2 arrangement of R5, with every colour index raised by 2. Lane 3 carries the reserved bit in slot 0 and B1, B0, G1, G0, R1, R0 in slots 1..6.
- R7: Mode 2 uses the lanes 0-2 arrangement of R5 for colour bits 5:0. Lane 3 carries the reserved bit in slot 0 and B7, B6, G7, G6, R7, R6 in slots 1..6.
- R8: In every mode, lane 2 carries data enable in slot 0, vertical sync in slot 1 and horizontal sync in slot 2.
- R9: `ctl_err_o` is set when a word completes while locked in mode 1 or 2 with the lane 3 slot 0 bit equal to 1. It stays set until reset, and such words do not set it before lock.
- R10: After reset, `lock_o`, `pix_valid_o`, `ctl_err_o` and all pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven cycles per pixel |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_lane_i | input | 1 | Sampled clock-pair bit |
| data_lane_i | input | 4 | Sampled bit of data pairs 0..3 |
| mode_i | input | 2 | 0/3 18-bit, 1 and 2 the two 24-bit layouts |
| red_o | output | 8 | Recovered red |
| green_o | output | 8 | Recovered green |
| blue_o | output | 8 | Recovered blue |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_valid_o | output | 1 | One-cycle strobe per pixel |
| lock_o | output | 1 | Word alignment held |
| ctl_err_o | output | 1 | Sticky reserved-bit error |

## Verification
The slot 6 bit of a word is combined with the six stored bits, so the pixel, strobe, lock and error results all become visible one register stage after the edge that samples that bit. There is no extra word of latency. The bench drives each slot on a falling edge. After the last slot it waits for the next rising edge and samples 1 ns later, so every result of that word is checked in its due cycle. The strobe is also sampled in the middle of each word to confirm that it lasts one cycle. Because words are sent back to back with no gap bits, the tracking phase stays in step between checks.

// File: rtl/lvds_pixel_deser.sv
module lvds_pixel_deser #(
  parameter int LOCK_WORDS = 4,
  parameter int DROP_WORDS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_lane_i,
  input  logic [3:0] data_lane_i,
  input  logic [1:0] mode_i,
  output logic [7:0] red_o,
  output logic [7:0] green_o,
  output logic [7:0] blue_o,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       de_o,
  output logic       pix_valid_o,
  output logic       lock_o,
  output logic       ctl_err_o
);
  localparam int          SLOTS    = 7;
  localparam logic [6:0]  FRAME_PAT = 7'b1100011;
  localparam int          GW = $clog2(LOCK_WORDS + 1);
  localparam int          DW = $clog2(DROP_WORDS + 1);
  localparam logic [2:0]  LAST_PH = 3'(SLOTS - 1);

  logic [5:0] ck_sr;
  logic [5:0] ln_sr [4];
  logic [6:0] ck_w;
  logic [6:0] w0, w1, w2, w3;

  assign ck_w = {ck_sr, clk_lane_i};
  assign w0 = {ln_sr[0], data_lane_i[0]};
  assign w1 = {ln_sr[1], data_lane_i[1]};
  assign w2 = {ln_sr[2], data_lane_i[2]};
  assign w3 = {ln_sr[3], data_lane_i[3]};

  logic [2:0]    ph;
  logic [GW-1:0] good_cnt;
  logic [DW-1:0] bad_cnt;

  wire hit       = (ck_w == FRAME_PAT);
  wire searching = (good_cnt == '0) && !lock_o;
  wire boundary  = searching ? hit : (ph == LAST_PH);
  wire take      = boundary && lock_o;
  wire wide      = (mode_i == 2'd1) || (mode_i == 2'd2);

  wire [5:0] r6 = w0[5:0];
  wire [5:0] g6 = {w1[4:0], w0[6]};
  wire [5:0] b6 = {w2[3:0], w1[6], w1[5]};

  logic [7:0] r_n, g_n, b_n;
  always_comb begin
    case (mode_i)
      2'd1: begin
        r_n = {r6, w3[1], w3[0]};
        g_n = {g6, w3[3], w3[2]};
        b_n = {b6, w3[5], w3[4]};
      end
      2'd2: begin
        r_n = {w3[1], w3[0], r6};
        g_n = {w3[3], w3[2], g6};
        b_n = {w3[5], w3[4], b6};
      end
      default: begin
        r_n = {2'b00, r6};
        g_n = {2'b00, g6};
        b_n = {2'b00, b6};
      end
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ln_sr[gi] <= '0;
        else        ln_sr[gi] <= {ln_sr[gi][4:0], data_lane_i[gi]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sr    <= '0;
      ph       <= '0;
      good_cnt <= '0;
      bad_cnt  <= '0;
      lock_o   <= 1'b0;
    end else begin
      ck_sr <= ck_w[5:0];
      if (searching) begin
        if (hit) begin
          good_cnt <= GW'(1);
          ph       <= '0;
        end
      end else begin
        ph <= (ph == LAST_PH) ? 3'd0 : ph + 3'd1;
        if (ph == LAST_PH) begin
          if (hit) begin
            bad_cnt <= '0;
            if (good_cnt != GW'(LOCK_WORDS)) good_cnt <= good_cnt + GW'(1);
            if (good_cnt == GW'(LOCK_WORDS - 1)) lock_o <= 1'b1;
          end else if (!lock_o) begin
            good_cnt <= '0;
          end else if (bad_cnt == DW'(DROP_WORDS - 1)) begin
            lock_o   <= 1'b0;
            good_cnt <= '0;
            bad_cnt  <= '0;
          end else begin
            bad_cnt <= bad_cnt + DW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_o       <= '0;
      green_o     <= '0;
      blue_o      <= '0;
      hsync_o     <= 1'b0;
      vsync_o     <= 1'b0;
      de_o        <= 1'b0;
      pix_valid_o <= 1'b0;
      ctl_err_o   <= 1'b0;
    end else begin
      pix_valid_o <= take;
      if (take) begin
        red_o   <= r_n;
        green_o <= g_n;
        blue_o  <= b_n;
        de_o    <= w2[6];
        vsync_o <= w2[5];
        hsync_o <= w2[4];
        if (wide && w3[6]) ctl_err_o <= 1'b1;
      end
    end
  end
endmodule

module lvds_pixel_deser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_lane_i,
  input logic [1:0] mode_i,
  input logic [7:0] red_o,
  input logic [7:0] green_o,
  input logic [7:0] blue_o,
  input logic       pix_valid_o,
  input logic       lock_o,
  input logic       ctl_err_o
);
  assert_lock_on_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(clk_lane_i));

  assert_valid_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> $past(lock_o));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |=> !pix_valid_o);

  assert_narrow_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && ($past(mode_i) == 2'd0 || $past(mode_i) == 2'd3))
      |-> (red_o[7:6] == 2'b00 && green_o[7:6] == 2'b00 && blue_o[7:6] == 2'b00));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_err_o |=> ctl_err_o);

  assert_err_when_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_err_o) |-> ($past(lock_o) && pix_valid_o));
endmodule

bind lvds_pixel_deser lvds_pixel_deser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_lane_i(clk_lane_i), .mode_i(mode_i),
  .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
  .pix_valid_o(pix_valid_o), .lock_o(lock_o), .ctl_err_o(ctl_err_o)
);

// File: tb/lvds_pixel_deser_test.sv
module lvds_pixel_deser_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_lane_i = 1'b0;
  logic [3:0] data_lane_i = '0;
  logic [1:0] mode_i = 2'd1;
  logic [7:0] red_o, green_o, blue_o;
  logic       hsync_o, vsync_o, de_o, pix_valid_o, lock_o, ctl_err_o;

  int n_chk = 0;
  int n_err = 0;
  logic mid_valid;

  lvds_pixel_deser uut (
    .clk(clk), .rst_n(rst_n), .clk_lane_i(clk_lane_i), .data_lane_i(data_lane_i),
    .mode_i(mode_i), .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_valid_o(pix_valid_o),
    .lock_o(lock_o), .ctl_err_o(ctl_err_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic stray_bits(input logic [2:0] bits);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      clk_lane_i  = bits[i];
      data_lane_i = '0;
    end
  endtask

  // one word; bit s of each lane vector is slot s; ends 1 ns after the edge taking slot 6
  task automatic send_word(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                           input logic hs, input logic vs, input logic de,
                           input logic c3, input logic good_clk);
    logic [6:0] l0, l1, l2, l3, ck;
    int o;
    o  = (mode_i == 2'd1) ? 2 : 0;
    ck = good_clk ? 7'b1100011 : 7'b1111111;
    l0[0] = g[o];
    for (int k = 1; k < 7; k++) l0[k] = r[6 - k + o];
    l1[0] = b[1 + o];
    l1[1] = b[o];
    for (int k = 2; k < 7; k++) l1[k] = g[7 - k + o];
    l2[0] = de; l2[1] = vs; l2[2] = hs;
    for (int k = 3; k < 7; k++) l2[k] = b[8 - k + o];
    if (mode_i == 2'd1)      l3 = {r[0], r[1], g[0], g[1], b[0], b[1], c3};
    else if (mode_i == 2'd2) l3 = {r[6], r[7], g[6], g[7], b[6], b[7], c3};
    else                     l3 = 7'h7F;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      clk_lane_i  = ck[s];
      data_lane_i = {l3[s], l2[s], l1[s], l0[s]};
      if (s == 4) mid_valid = pix_valid_o;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 lock", lock_o, 0);
    chk("R10 valid", pix_valid_o, 0);
    chk("R10 err", ctl_err_o, 0);
    chk("R10 pixel", {red_o, green_o, blue_o, hsync_o, vsync_o, de_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_acquire;
    mode_i = 2'd1;
    stray_bits(3'b101);
    for (int i = 0; i < 3; i++) send_word(8'h11, 8'h22, 8'h33, 0, 0, 1, 1'b1, 1'b1);
    chk("R1 no lock after 3 words", lock_o, 0);
    send_word(8'h11, 8'h22, 8'h33, 0, 0, 1, 1'b1, 1'b1);
    chk("R1 lock after 4 words", lock_o, 1);
    chk("R4 no strobe on locking word", pix_valid_o, 0);
    chk("R9 reserved bit ignored before lock", ctl_err_o, 0);
  endtask

  task automatic t_layout_a;
    mode_i = 2'd1;
    send_word(8'hA5, 8'h3C, 8'h96, 1, 0, 1, 1'b0, 1'b1);
    chk("R4 strobe", pix_valid_o, 1);
    chk("R6 rgb", {red_o, green_o, blue_o}, 24'hA53C96);
    chk("R8 hs/vs/de", {hsync_o, vsync_o, de_o}, 3'b101);
    send_word(8'h5E, 8'hE1, 8'h0F, 0, 1, 1, 1'b0, 1'b1);
    chk("R4 strobe one cycle", mid_valid, 0);
    chk("R6 rgb second", {red_o, green_o, blue_o}, 24'h5EE10F);
  endtask

  task automatic t_layout_b;
    mode_i = 2'd2;
    send_word(8'h5A, 8'hC3, 8'h69, 0, 1, 0, 1'b0, 1'b1);
    chk("R7 rgb", {red_o, green_o, blue_o}, 24'h5AC369);
    chk("R8 hs/vs/de", {hsync_o, vsync_o, de_o}, 3'b010);
    send_word(8'hF0, 8'h0D, 8'hB2, 1, 1, 0, 1'b0, 1'b1);
    chk("R7 rgb second", {red_o, green_o, blue_o}, 24'hF00DB2);
  endtask

  task automatic t_narrow;
    mode_i = 2'd0;
    send_word(8'hEB, 8'hD5, 8'hFE, 1, 1, 1, 1'b1, 1'b1);
    chk("R5 rgb mode0", {red_o, green_o, blue_o}, 24'h2B153E);
    chk("R8 hs/vs/de", {hsync_o, vsync_o, de_o}, 3'b111);
    chk("R5 lane3 no error", ctl_err_o, 0);
    mode_i = 2'd3;
    send_word(8'h16, 8'h29, 8'h03, 0, 0, 0, 1'b1, 1'b1);
    chk("R5 rgb mode3", {red_o, green_o, blue_o}, 24'h162903);
    chk("R5 lane3 no error mode3", ctl_err_o, 0);
  endtask

  task automatic t_err;
    mode_i = 2'd2;
    send_word(8'h01, 8'h02, 8'h03, 0, 0, 1, 1'b1, 1'b1);
    chk("R9 error set", ctl_err_o, 1);
    send_word(8'h04, 8'h05, 8'h06, 0, 0, 1, 1'b0, 1'b1);
    chk("R9 error sticky", ctl_err_o, 1);
  endtask

  task automatic t_drop;
    mode_i = 2'd2;
    send_word(8'h10, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b0);
    chk("R3 single bad keeps lock", lock_o, 1);
    send_word(8'h10, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b1);
    send_word(8'h10, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b0);
    chk("R3 bad count cleared by good word", lock_o, 1);
    send_word(8'h10, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b0);
    chk("R3 two bad drop lock", lock_o, 0);
    send_word(8'h77, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b1);
    chk("R4 no strobe while unlocked", pix_valid_o, 0);
    chk("R4 pixel held while unlocked", red_o, 8'h10);
  endtask

  task automatic t_restart;
    send_word(8'h10, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b1);
    send_word(8'h10, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send_word(8'h10, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b1);
    chk("R2 count restarted", lock_o, 0);
    send_word(8'h10, 8'h20, 8'h30, 0, 0, 1, 1'b0, 1'b1);
    chk("R2 lock after four fresh words", lock_o, 1);
    send_word(8'h44, 8'h55, 8'h66, 0, 0, 1, 1'b0, 1'b1);
    chk("R4 strobe after relock", pix_valid_o, 1);
    chk("R7 rgb after relock", {red_o, green_o, blue_o}, 24'h445566);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire();
    t_layout_a();
    t_layout_b();
    t_narrow();
    t_err();
    t_drop();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule